// File: doc/BRIEF.md
# Fetch Output Stage with Skid Register and Static Branch Prediction

This block sits at the end of the instruction-fetch path of a small in-order core. Each fetch response (instruction word plus its address) is either handed straight to decode or, when decode is stalled, parked in a single-entry skid register until decode can take it. Every accepted instruction also runs through a static predictor. Backward conditional branches and all jumps send the fetch address to their target. Everything else moves it on to the fall-through address.

The block also produces the return PC that interrupt logic saves when it takes an interrupt. This PC comes from the skid entry while one is held, and from the live fetch address otherwise. When execute reports a mispredict, the stage does four things in that same cycle:

- It discards the skid entry.
- It drops any response that is still in flight.
- It moves the fetch address to the corrected fall-through address.
- It presents that corrected address as the return PC.

As a result, an interrupt that coincides with the recovery can never save the speculative target of a branch that was not taken.

Top module: `fetch_skid_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stage sets `fetch_pc` to the parameter `BOOT_ADDR` (0x100 by default) and `epc` to the same value, and empties the skid register. After that edge `rsp_ready` is 1 and `dec_valid` is 0 until a response is accepted.
- R2: A response is accepted when `rsp_valid` and `rsp_ready` are 1, `mispredict` is 0 and `rsp_addr` equals `fetch_pc`. If `dec_ready` is 1, the accepted instruction appears on `dec_instr`/`dec_pc` in the same cycle. A non-control 32-bit instruction (bits [1:0] = 11) advances `fetch_pc` by 4.
- R3: An accepted response with `dec_ready` low is captured in the skid register. While the skid register holds an entry, `rsp_ready` is 0 and `dec_valid`, `dec_pc` and `dec_instr` stay constant. The entry drains on the first cycle that `dec_ready` is 1.
- R4: A 32-bit conditional branch (opcode bits [6:0] = 1100011, B-type immediate, sign-extended) with a negative offset is predicted taken: `fetch_pc` becomes PC+offset and `dec_pred_taken` is 1. With a non-negative offset it is predicted not taken and `fetch_pc` becomes PC+4.
- R5: A 16-bit instruction (bits [1:0] not 11) advances `fetch_pc` by 2. A compressed conditional branch (quadrant 01, funct3 110 or 111) follows the sign rule of R4 with its own immediate. A compressed jump (quadrant 01, funct3 101 or 001) is always predicted taken.
- R6: A 32-bit jump (opcode 1101111, J-type immediate) is always predicted taken, and `fetch_pc` becomes PC+offset.
- R7: `ret_pc` equals the address of the skid entry while one is held, and `fetch_pc` otherwise.
- R8: In a cycle with `mispredict` high, `dec_valid` is 0, the skid register is emptied, `ret_pc` equals `fix_addr`, and `fetch_pc` becomes `fix_addr` on the next edge.
- R9: A response whose address differs from `fetch_pc`, or one that arrives while `mispredict` is high, is dropped. It reaches neither decode nor the skid register and leaves `fetch_pc` unchanged.
- R10: `epc` loads `ret_pc` on an edge where `irq_take` is 1 and otherwise holds. When `irq_take` and `mispredict` occur together, `epc` loads `fix_addr`.
- R11: After an interrupt taken during recovery from a mispredicted backward branch whose target sits in the skid register, `epc` never equals that predicted target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rsp_valid | input | 1 | Fetch response present |
| rsp_ready | output | 1 | Stage can accept a response (skid register empty) |
| rsp_addr | input | ADDR_W | Address of the fetched instruction |
| rsp_instr | input | 32 | Fetched instruction word (16-bit forms in bits [15:0]) |
| fetch_pc | output | ADDR_W | Address the stage expects to fetch next |
| dec_ready | input | 1 | Decode can take an instruction this cycle |
| dec_valid | output | 1 | Instruction presented to decode |
| dec_instr | output | 32 | Instruction presented to decode |
| dec_pc | output | ADDR_W | Address of the presented instruction |
| dec_pred_taken | output | 1 | Static prediction for the presented instruction |
| mispredict | input | 1 | Execute found a wrong prediction this cycle |
| fix_addr | input | ADDR_W | Corrected fall-through address for the mispredict |
| irq_take | input | 1 | Interrupt accepted this cycle |
| ret_pc | output | ADDR_W | Current return PC for an interrupt |
| epc | output | ADDR_W | Saved exception return address |

## Verification
Some properties are checked on every cycle:

- the stall contract: a held decode output stays constant, and `rsp_ready` stays low while an entry is parked;
- the squash of decode output and the redirect of `fetch_pc` on a mispredict;
- the dropping of mismatched responses;
- the way `epc` loads or holds, including the case where the corrected address wins over the skid address.

Two things can only be shown by the bench's scenarios. The first is that the predictor chooses the right next address for each instruction form. The second is the failing sequence itself: a backward branch is wrongly predicted taken, its target is parked while decode stalls, and a mispredict arrives together with an interrupt. That scenario checks that `epc` holds the fall-through address and not the parked target.

// File: rtl/fsk_pkg.sv
`timescale 1ns/1ps
// Package: shared types and immediate decoders for the fetch skid stage.
// Assumes RV32-style encodings; 16-bit forms live in the low half-word.
package fsk_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned HALF_W  = 16;

    typedef enum logic [1:0] {
        CF_NONE = 2'd0,
        CF_COND = 2'd1,
        CF_JUMP = 2'd2
    } cf_kind_e;

    typedef struct packed {
        cf_kind_e             kind;
        logic [INSTR_W-1:0]   offset;
    } cf_info_t;

    // Classify a 32-bit word and extract its sign-extended branch offset.
    function automatic cf_info_t decode_full(input logic [INSTR_W-1:0] w);
        cf_info_t r;
        r.kind   = CF_NONE;
        r.offset = '0;
        if (w[6:0] == 7'b1100011) begin
            r.kind   = CF_COND;
            r.offset = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        end else if (w[6:0] == 7'b1101111) begin
            r.kind   = CF_JUMP;
            r.offset = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        end
        return r;
    endfunction

    // Classify a 16-bit word and extract its sign-extended branch offset.
    function automatic cf_info_t decode_half(input logic [HALF_W-1:0] h);
        cf_info_t r;
        r.kind   = CF_NONE;
        r.offset = '0;
        if (h[1:0] == 2'b01) begin
            if (h[15:13] == 3'b110 || h[15:13] == 3'b111) begin
                r.kind   = CF_COND;
                r.offset = {{23{h[12]}}, h[12], h[6:5], h[2], h[11:10], h[4:3], 1'b0};
            end else if (h[15:13] == 3'b101 || h[15:13] == 3'b001) begin
                r.kind   = CF_JUMP;
                r.offset = {{20{h[12]}}, h[12], h[8], h[10:9], h[6], h[7], h[2],
                            h[11], h[5:3], 1'b0};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/fsk_static_pred.sv
`timescale 1ns/1ps
// Module: static predictor. Backward conditional branches and all jumps are
// predicted taken; anything else falls through by its own length.
// Assumes: pure combinational; RVC_EN selects whether 16-bit forms exist.
module fsk_static_pred
    import fsk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter bit          RVC_EN = 1'b1
) (
    input  logic [ADDR_W-1:0]  pc,
    input  logic [INSTR_W-1:0] instr,
    output logic               taken,
    output logic [ADDR_W-1:0]  next_pc
);

    localparam logic [ADDR_W-1:0] STEP_FULL = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);

    cf_info_t          info_full;
    cf_info_t          info_half;
    cf_info_t          info;
    logic              is_half;
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] fall_pc;

    assign info_full = decode_full(instr);

    // Pick the 16-bit decoder only when compressed support is built in.
    generate
        if (RVC_EN) begin : g_rvc
            assign is_half   = (instr[1:0] != 2'b11);
            assign info_half = decode_half(instr[HALF_W-1:0]);
        end else begin : g_no_rvc
            assign is_half   = 1'b0;
            assign info_half = '{kind: CF_NONE, offset: '0};
        end
    endgenerate

    // Merge the decoders and form the predicted next address.
    always_comb begin
        info    = is_half ? info_half : info_full;
        off_ext = ADDR_W'($signed(info.offset));
        fall_pc = pc + (is_half ? STEP_HALF : STEP_FULL);
        taken   = (info.kind == CF_JUMP) ||
                  ((info.kind == CF_COND) && info.offset[INSTR_W-1]);
        next_pc = taken ? (pc + off_ext) : fall_pc;
    end

endmodule

// File: rtl/fsk_skid_reg.sv
`timescale 1ns/1ps
// Module: single-entry skid register for one fetched instruction.
// Assumes: load is only raised while empty; clear wins over load and drain.
module fsk_skid_reg
    import fsk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               drain,
    input  logic               clear,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [INSTR_W-1:0] in_instr,
    input  logic               in_pred,
    output logic               valid,
    output logic [ADDR_W-1:0]  addr,
    output logic [INSTR_W-1:0] instr,
    output logic               pred
);

    // Occupancy flag: emptied by reset, a squash or a drain; set by a load.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid <= 1'b0;
        else if (clear) valid <= 1'b0;
        else if (load)  valid <= 1'b1;
        else if (drain) valid <= 1'b0;
    end

    // Payload capture; contents are don't-care while the flag is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            instr <= '0;
            pred  <= 1'b0;
        end else if (load && !clear) begin
            addr  <= in_addr;
            instr <= in_instr;
            pred  <= in_pred;
        end
    end

endmodule

// File: rtl/fsk_pc_track.sv
`timescale 1ns/1ps
// Module: fetch address register, return-PC selection and saved return PC.
// Assumes: a redirect from a mispredict outranks a predicted advance.
module fsk_pc_track #(
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = ADDR_W'(32'h100)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic              advance,
    input  logic [ADDR_W-1:0] advance_addr,
    input  logic              skid_valid,
    input  logic [ADDR_W-1:0] skid_addr,
    input  logic              irq_take,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] ret_pc,
    output logic [ADDR_W-1:0] epc
);

    // Next fetch address: corrected address first, then the prediction.
    always_ff @(posedge clk) begin
        if (!rst_n)        fetch_pc <= BOOT_ADDR;
        else if (redirect) fetch_pc <= redirect_addr;
        else if (advance)  fetch_pc <= advance_addr;
    end

    // Return PC: a recovering mispredict overrides any parked speculative entry.
    always_comb begin
        if (redirect)        ret_pc = redirect_addr;
        else if (skid_valid) ret_pc = skid_addr;
        else                 ret_pc = fetch_pc;
    end

    // Saved return address, written only when an interrupt is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)        epc <= BOOT_ADDR;
        else if (irq_take) epc <= ret_pc;
    end

endmodule

// File: rtl/fetch_skid_stage.sv
`timescale 1ns/1ps
// Module: fetch output stage. Accepts in-order fetch responses, predicts
// statically, parks one instruction while decode stalls and recovers
// cleanly from a mispredict, including the saved interrupt return PC.
// Assumes: responses return in order; a mismatching address is stale.
module fetch_skid_stage
    import fsk_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = ADDR_W'(32'h100),
    parameter bit                RVC_EN    = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [ADDR_W-1:0]  rsp_addr,
    input  logic [INSTR_W-1:0] rsp_instr,
    output logic [ADDR_W-1:0]  fetch_pc,
    input  logic               dec_ready,
    output logic               dec_valid,
    output logic [INSTR_W-1:0] dec_instr,
    output logic [ADDR_W-1:0]  dec_pc,
    output logic               dec_pred_taken,
    input  logic               mispredict,
    input  logic [ADDR_W-1:0]  fix_addr,
    input  logic               irq_take,
    output logic [ADDR_W-1:0]  ret_pc,
    output logic [ADDR_W-1:0]  epc
);

    logic               rsp_take;
    logic               pred_taken;
    logic [ADDR_W-1:0]  pred_next;
    logic               skid_valid;
    logic [ADDR_W-1:0]  skid_addr;
    logic [INSTR_W-1:0] skid_instr;
    logic               skid_pred;

    // Acceptance: room, no squash, and the address the stage is waiting for.
    always_comb begin
        rsp_ready = !skid_valid;
        rsp_take  = rsp_valid && rsp_ready && !mispredict && (rsp_addr == fetch_pc);
    end

    fsk_static_pred #(
        .ADDR_W (ADDR_W),
        .RVC_EN (RVC_EN)
    ) i_pred (
        .pc      (rsp_addr),
        .instr   (rsp_instr),
        .taken   (pred_taken),
        .next_pc (pred_next)
    );

    fsk_skid_reg #(
        .ADDR_W (ADDR_W)
    ) i_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rsp_take && !dec_ready),
        .drain    (dec_ready),
        .clear    (mispredict),
        .in_addr  (rsp_addr),
        .in_instr (rsp_instr),
        .in_pred  (pred_taken),
        .valid    (skid_valid),
        .addr     (skid_addr),
        .instr    (skid_instr),
        .pred     (skid_pred)
    );

    fsk_pc_track #(
        .ADDR_W    (ADDR_W),
        .BOOT_ADDR (BOOT_ADDR)
    ) i_pc (
        .clk           (clk),
        .rst_n         (rst_n),
        .redirect      (mispredict),
        .redirect_addr (fix_addr),
        .advance       (rsp_take),
        .advance_addr  (pred_next),
        .skid_valid    (skid_valid),
        .skid_addr     (skid_addr),
        .irq_take      (irq_take),
        .fetch_pc      (fetch_pc),
        .ret_pc        (ret_pc),
        .epc           (epc)
    );

    // Decode view: the parked entry first, else the live response; squashed on mispredict.
    always_comb begin
        dec_valid      = !mispredict && (skid_valid || rsp_take);
        dec_instr      = skid_valid ? skid_instr : rsp_instr;
        dec_pc         = skid_valid ? skid_addr  : rsp_addr;
        dec_pred_taken = skid_valid ? skid_pred  : pred_taken;
    end

endmodule

// File: rtl/fetch_skid_stage_chk.sv
`timescale 1ns/1ps
// Module: protocol and recovery checker, attached to fetch_skid_stage by bind.
// Assumes: only observes ports of the bound instance.
module fetch_skid_stage_chk #(
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = ADDR_W'(32'h100)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              dec_ready,
    input logic              dec_valid,
    input logic [31:0]       dec_instr,
    input logic [ADDR_W-1:0] dec_pc,
    input logic              mispredict,
    input logic [ADDR_W-1:0] fix_addr,
    input logic              irq_take,
    input logic [ADDR_W-1:0] ret_pc,
    input logic [ADDR_W-1:0] epc
);

    p_boot_r1: assert property (@(posedge clk)
        !rst_n |=> (fetch_pc == BOOT_ADDR) && rsp_ready);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !dec_ready && !mispredict |=>
            mispredict || (dec_valid && $stable(dec_pc) && $stable(dec_instr)));

    p_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !dec_ready && !mispredict |=> !rsp_ready);

    p_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> !dec_valid);

    p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> fetch_pc == $past(fix_addr));

    p_stale_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_addr != fetch_pc) && !mispredict |=> $stable(fetch_pc));

    p_save_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> epc == $past(ret_pc));

    p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_take |=> $stable(epc));

    p_fix_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take && mispredict |=> epc == $past(fix_addr));

endmodule

bind fetch_skid_stage fetch_skid_stage_chk #(
    .ADDR_W    (ADDR_W),
    .BOOT_ADDR (BOOT_ADDR)
) i_chk (.*);

// File: tb/test_fetch_skid_stage.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected decode hand-overs plus direct port checks.
module test_fetch_skid_stage;

    localparam logic [31:0] NOP32 = 32'h0000_0013;
    localparam logic [31:0] NOP16 = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_addr = '0;
    logic [31:0] rsp_instr = '0;
    logic [31:0] fetch_pc;
    logic        dec_ready = 1'b1;
    logic        dec_valid;
    logic [31:0] dec_instr;
    logic [31:0] dec_pc;
    logic        dec_pred_taken;
    logic        mispredict = 1'b0;
    logic [31:0] fix_addr = '0;
    logic        irq_take = 1'b0;
    logic [31:0] ret_pc;
    logic [31:0] epc;

    int vecs = 0;
    int bad  = 0;
    logic [64:0] sb[$];

    always #2 clk = ~clk;

    fetch_skid_stage i_fetch_skid_stage (.*);

    function automatic logic [31:0] enc_b(input int off);
        logic [31:0] o = off;
        return {o[12], o[10:5], 5'd0, 5'd0, 3'b000, o[4:1], o[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_j(input int off);
        logic [31:0] o = off;
        return {o[20], o[10:1], o[11], o[19:12], 5'd1, 7'b1101111};
    endfunction
    function automatic logic [31:0] enc_cb(input int off);
        logic [31:0] o = off;
        return {16'd0, 3'b110, o[8], o[4:3], 3'b000, o[7:6], o[2:1], o[5], 2'b01};
    endfunction
    function automatic logic [31:0] enc_cj(input int off);
        logic [31:0] o = off;
        return {16'd0, 3'b101, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vecs++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Driver side of the scoreboard: record a hand-over decode must see.
    task automatic expect_dec(input logic [31:0] a, input logic [31:0] ins, input logic p);
        sb.push_back({p, a, ins});
    endtask

    // One cycle of stimulus, applied at the falling edge; returns 1 ns later.
    task automatic cyc(input logic rv, input logic [31:0] a, input logic [31:0] ins,
                       input logic dr, input logic mp, input logic [31:0] fx, input logic irq);
        @(negedge clk);
        rsp_valid = rv; rsp_addr = a; rsp_instr = ins;
        dec_ready = dr; mispredict = mp; fix_addr = fx; irq_take = irq;
        #1;
    endtask

    // Monitor: every completed hand-over is compared with the queue head (R2, R3).
    always begin
        @(negedge clk);
        #1;
        if (rst_n && dec_valid && dec_ready) begin
            vecs++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected hand-over: got pc %h expected none", dec_pc);
            end else begin
                logic [64:0] e;
                e = sb.pop_front();
                if ({dec_pred_taken, dec_pc, dec_instr} !== e) begin
                    bad++;
                    $display("FAIL R2/R4 hand-over: got %h expected %h",
                             {dec_pred_taken, dec_pc, dec_instr}, e);
                end
            end
        end
    end

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R1 fetch_pc", fetch_pc, 32'h100);
        chk("R1 epc", epc, 32'h100);
        chk("R1 rsp_ready", 32'(rsp_ready), 1);
        chk("R1 dec_valid", 32'(dec_valid), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: straight hand-over
        expect_dec(32'h100, NOP32, 0);
        cyc(1, 32'h100, NOP32, 1, 0, 0, 0);
        chk("R7 ret_pc live", ret_pc, 32'h100);
        expect_dec(32'h104, enc_b(32), 0);
        cyc(1, 32'h104, enc_b(32), 1, 0, 0, 0);
        chk("R2 advance by 4", fetch_pc, 32'h104);
        expect_dec(32'h108, enc_b(-16), 1);
        cyc(1, 32'h108, enc_b(-16), 1, 0, 0, 0);
        chk("R4 forward not taken", fetch_pc, 32'h108);
        // R9: stale response from before the redirect
        cyc(1, 32'h10C, NOP32, 1, 0, 0, 0);
        chk("R4 backward taken", fetch_pc, 32'hF8);
        chk("R9 stale not presented", 32'(dec_valid), 0);
        // R5: compressed forms
        expect_dec(32'hF8, NOP16, 0);
        cyc(1, 32'hF8, NOP16, 1, 0, 0, 0);
        chk("R9 stale left fetch_pc", fetch_pc, 32'hF8);
        expect_dec(32'hFA, enc_cb(-8), 1);
        cyc(1, 32'hFA, enc_cb(-8), 1, 0, 0, 0);
        chk("R5 half advance by 2", fetch_pc, 32'hFA);
        expect_dec(32'hF2, enc_cj(32'h20), 1);
        cyc(1, 32'hF2, enc_cj(32'h20), 1, 0, 0, 0);
        chk("R5 compressed backward branch", fetch_pc, 32'hF2);
        expect_dec(32'h112, enc_j(32'h40), 1);
        cyc(1, 32'h112, enc_j(32'h40), 1, 0, 0, 0);
        chk("R5 compressed jump", fetch_pc, 32'h112);
        // R3: stall parks an instruction
        expect_dec(32'h152, NOP32, 0);
        cyc(1, 32'h152, NOP32, 0, 0, 0, 0);
        chk("R6 jump taken", fetch_pc, 32'h152);
        chk("R3 presented while stalled", dec_pc, 32'h152);
        cyc(1, 32'h156, NOP32, 0, 0, 0, 0);
        chk("R3 ready low when full", 32'(rsp_ready), 0);
        chk("R3 held pc", dec_pc, 32'h152);
        chk("R7 ret_pc from skid", ret_pc, 32'h152);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R3 refused offer", fetch_pc, 32'h156);
        chk("R3 drain valid", 32'(dec_valid), 1);
        // R11 scenario: wrong backward prediction, target parked, mispredict + interrupt
        expect_dec(32'h156, enc_b(-32), 1);
        cyc(1, 32'h156, enc_b(-32), 1, 0, 0, 0);
        chk("R3 ready after drain", 32'(rsp_ready), 1);
        cyc(1, 32'h136, NOP32, 0, 0, 0, 0);
        chk("R4 predicted target", fetch_pc, 32'h136);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R7 speculative parked", ret_pc, 32'h136);
        cyc(0, 0, 0, 0, 1, 32'h15A, 1);
        chk("R8 squash", 32'(dec_valid), 0);
        chk("R8 ret_pc corrected", ret_pc, 32'h15A);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R10 epc corrected", epc, 32'h15A);
        chk("R11 epc not target", 32'(epc != 32'h136), 1);
        chk("R8 fetch_pc corrected", fetch_pc, 32'h15A);
        chk("R8 skid cleared", 32'(rsp_ready), 1);
        chk("R8 nothing presented", 32'(dec_valid), 0);
        // R10: plain interrupt
        expect_dec(32'h15A, NOP32, 0);
        cyc(1, 32'h15A, NOP32, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 1);
        chk("R7 ret_pc after advance", ret_pc, 32'h15E);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R10 epc saved", epc, 32'h15E);
        // R9: response during a mispredict, then a late stale one
        cyc(1, 32'h15E, NOP32, 0, 1, 32'h200, 0);
        chk("R9 dropped under mispredict", 32'(dec_valid), 0);
        cyc(1, 32'h162, NOP32, 1, 0, 0, 0);
        chk("R8 redirect", fetch_pc, 32'h200);
        chk("R10 epc held", epc, 32'h15E);
        chk("R9 late stale not presented", 32'(dec_valid), 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R9 late stale ignored", fetch_pc, 32'h200);
        chk("R9 skid stayed empty", 32'(rsp_ready), 1);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R2 scoreboard drained", sb.size(), 0);
        summary();
    end

endmodule